// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block is the multiply/divide engine of an integer core. It accepts one operation per cycle over a valid/ready handshake. The operations are 32-bit and 64-bit multiplies, a 32-bit multiply-accumulate, 32-bit and 64-bit divides, writes into the HI and LO result registers, and reads of HI or LO back to the integer pipeline. Each operation has its own occupancy. While an earlier operation still holds the unit, `in_ready` stays low and any offered operation is ignored.

HI and LO are 64 bits wide. A 32-bit operation uses only the low 32 bits of its operands and writes each 32-bit half of its result sign-extended to 64 bits. Reads of HI or LO, and the integer result of a multiply-accumulate, leave on a single writeback port after a fixed latency of three cycles. Division is an iterative restoring shift-subtract loop that works on operand magnitudes. The signs are fixed when the result is written: the quotient is truncated toward zero and the remainder takes the sign of the dividend.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `in_ready` is 1, `wb_valid` is 0, and HI and LO both read back as zero.
- R2: A 32-bit multiply (op 0) has an occupancy of one cycle, so `in_ready` stays high in the next cycle. The product of the low operand halves (signed when `in_sgn`=1) is placed in HI/LO one cycle after issue. LO gets product bits 31:0 and HI gets bits 63:32, each sign-extended to 64 bits.
- R3: A read of HI (op 7) or LO (op 8) gives `wb_valid`=1 for exactly one cycle, in the third cycle after the read is accepted. `wb_data` carries the register value as it stood when the read was accepted.
- R4: A 64-bit multiply (op 1) holds `in_ready` low for the two cycles after issue. From the third cycle, HI holds bits 127:64 and LO holds bits 63:0 of the full 128-bit product.
- R5: A 32-bit multiply-accumulate (op 2) adds the 64-bit product to {HI[31:0],LO[31:0]}. It writes both halves back sign-extended and has a one-cycle occupancy, so dependent accumulates issue in consecutive cycles. Three cycles after issue it puts the new LO on the writeback port.
- R6: A 32-bit divide (op 3) holds `in_ready` low for 35 cycles after issue, for 36 cycles of occupancy. LO then holds the quotient and HI the remainder, each sign-extended from 32 bits. Quotients truncate toward zero and remainders take the dividend's sign.
- R7: A 64-bit divide (op 4) holds `in_ready` low for 71 cycles after issue, for 72 cycles of occupancy. It writes the 64-bit quotient to LO and the remainder to HI.
- R8: A write to HI (op 5) or LO (op 6) copies `in_a` into that register by the next cycle and has a one-cycle occupancy.
- R9: An operation offered while `in_ready` is low is ignored: it changes neither HI nor LO and produces no writeback.
- R10: An unsigned 64-bit divide by zero leaves all ones in LO and the dividend in HI.
- R11: The unused op codes 9 to 15 are accepted and change neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit free; operation accepted when both are high |
| in_op | input | 4 | Operation code (0 mul32, 1 mul64, 2 macc32, 3 div32, 4 div64, 5 write HI, 6 write LO, 7 read HI, 8 read LO) |
| in_sgn | input | 1 | Treat operands as signed |
| in_a | input | 64 | First operand / dividend / value to write |
| in_b | input | 64 | Second operand / divisor |
| wb_valid | output | 1 | Integer writeback result present |
| wb_data | output | 64 | Integer writeback value |

## Verification
HI and LO are observed only through read operations, so a corrupted result register appears on `wb_data` three cycles after the next read. A wrong occupancy count appears at once as an `in_ready` window of the wrong length, and the bench measures that window exactly for every multi-cycle operation. A divider that mishandles its sign fixup or its shift loop appears in the quotient or remainder written at the close of the divide window, which the bench reads back straight away for positive, negative, mixed-sign and zero-divisor operands.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int MULD_OCC = 3,
  parameter int DIVW_OCC = 36,
  parameter int DIVD_OCC = 72,
  parameter int MF_LAT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  in_op,
  input  logic        in_sgn,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        wb_valid,
  output logic [63:0] wb_data
);
  localparam int CW = $clog2(DIVD_OCC + 1);
  localparam logic [3:0] OP_MULW = 4'd0, OP_MULD = 4'd1, OP_MACC = 4'd2,
                         OP_DIVW = 4'd3, OP_DIVD = 4'd4, OP_MTHI = 4'd5,
                         OP_MTLO = 4'd6, OP_MFHI = 4'd7, OP_MFLO = 4'd8;
  typedef enum logic [1:0] {PK_NONE, PK_MULD, PK_DIV} pend_e;

  logic [CW-1:0] cnt;
  logic [63:0]   hi_r, lo_r, phi, plo;
  pend_e         pkind;
  logic [64:0]   rem;
  logic [63:0]   quo, den;
  logic [6:0]    steps;
  logic          div_w, neg_q, neg_r;
  logic [MF_LAT-1:0] pv;
  logic [63:0]   pd [MF_LAT];

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  wire fire = in_valid & in_ready;
  assign in_ready = (cnt == '0);

  wire [63:0] a32 = in_sgn ? sx32(in_a[31:0]) : {32'd0, in_a[31:0]};
  wire [63:0] b32 = in_sgn ? sx32(in_b[31:0]) : {32'd0, in_b[31:0]};
  wire [63:0] mulw_p = a32 * b32;
  wire [63:0] acc = {hi_r[31:0], lo_r[31:0]} + mulw_p;
  wire [127:0] ea = {{64{in_sgn & in_a[63]}}, in_a};
  wire [127:0] eb = {{64{in_sgn & in_b[63]}}, in_b};
  wire [127:0] muld_p = ea * eb;

  wire        is_w   = (in_op == OP_DIVW);
  wire [63:0] va     = is_w ? a32 : in_a;
  wire [63:0] vb     = is_w ? b32 : in_b;
  wire        sa     = in_sgn & va[63];
  wire        sb     = in_sgn & vb[63];
  wire [63:0] mag_a  = sa ? -va : va;
  wire [63:0] mag_b  = sb ? -vb : vb;

  wire [64:0] rsh = {rem[63:0], quo[63]};
  wire        ge  = rsh >= {1'b0, den};

  wire [31:0] q32 = neg_q ? -quo[31:0] : quo[31:0];
  wire [31:0] r32 = neg_r ? -rem[31:0] : rem[31:0];
  wire [63:0] q64 = neg_q ? -quo : quo;
  wire [63:0] r64 = neg_r ? -rem[63:0] : rem[63:0];

  logic        wbi_v;
  logic [63:0] wbi_d;
  always_comb begin
    wbi_v = fire & (in_op == OP_MFHI || in_op == OP_MFLO || in_op == OP_MACC);
    unique case (in_op)
      OP_MFHI: wbi_d = hi_r;
      OP_MACC: wbi_d = sx32(acc[31:0]);
      default: wbi_d = lo_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; hi_r <= '0; lo_r <= '0; phi <= '0; plo <= '0;
      pkind <= PK_NONE; rem <= '0; quo <= '0; den <= '0; steps <= '0;
      div_w <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0; pv <= '0;
      for (int i = 0; i < MF_LAT; i++) pd[i] <= '0;
    end else begin
      pv    <= {pv[MF_LAT-2:0], wbi_v};
      pd[0] <= wbi_d;
      for (int i = 1; i < MF_LAT; i++) pd[i] <= pd[i-1];
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (steps != '0) begin
        rem   <= ge ? rsh - {1'b0, den} : rsh;
        quo   <= {quo[62:0], ge};
        steps <= steps - 1'b1;
      end
      if (cnt == CW'(1)) begin
        if (pkind == PK_MULD) begin
          hi_r <= phi; lo_r <= plo;
        end else if (pkind == PK_DIV) begin
          hi_r <= div_w ? sx32(r32) : r64;
          lo_r <= div_w ? sx32(q32) : q64;
        end
        pkind <= PK_NONE;
      end
      if (fire) begin
        unique case (in_op)
          OP_MULW: begin
            lo_r <= sx32(mulw_p[31:0]); hi_r <= sx32(mulw_p[63:32]);
          end
          OP_MACC: begin
            lo_r <= sx32(acc[31:0]); hi_r <= sx32(acc[63:32]);
          end
          OP_MULD: begin
            phi <= muld_p[127:64]; plo <= muld_p[63:0];
            pkind <= PK_MULD; cnt <= CW'(MULD_OCC - 1);
          end
          OP_DIVW, OP_DIVD: begin
            rem   <= '0;
            quo   <= is_w ? {mag_a[31:0], 32'd0} : mag_a;
            den   <= mag_b;
            steps <= is_w ? 7'd32 : 7'd64;
            div_w <= is_w;
            neg_q <= sa ^ sb;
            neg_r <= sa;
            pkind <= PK_DIV;
            cnt   <= is_w ? CW'(DIVW_OCC - 1) : CW'(DIVD_OCC - 1);
          end
          OP_MTHI: hi_r <= in_a;
          OP_MTLO: lo_r <= in_a;
          default: ;
        endcase
      end
    end
  end

  assign wb_valid = pv[MF_LAT-1];
  assign wb_data  = pd[MF_LAT-1];
endmodule

module muldiv_hilo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_op,
  input logic        wb_valid,
  input logic [63:0] hi,
  input logic [63:0] lo
);
  wire fire = in_valid & in_ready;

  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> in_ready && !wb_valid);

  // R2
  mulw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd0 |=> in_ready);

  // R3
  mf_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == 4'd7 || in_op == 4'd8) |=> ##2 wb_valid);

  // R4
  muld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd1 |=> !in_ready ##1 !in_ready ##1 in_ready);

  // R5
  macc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd2 |=> in_ready ##2 wb_valid);

  // R6
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == 4'd3 || in_op == 4'd4) |=> !in_ready && $stable(lo) && $stable(hi));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && $past(!in_ready) && $past(rst_n) |-> $stable(hi) && $stable(lo));
endmodule

bind muldiv_hilo muldiv_hilo_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .wb_valid(wb_valid), .hi(hi_r), .lo(lo_r)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sgn = 1'b0, in_ready, wb_valid;
  logic [3:0] in_op = '0;
  logic [63:0] in_a = '0, in_b = '0, wb_data;
  int checks = 0, errors = 0;

  localparam logic [3:0] MULW = 0, MULD = 1, MACC = 2, DIVW = 3, DIVD = 4,
                         WHI = 5, WLO = 6, RHI = 7, RLO = 8;

  always #10 clk = ~clk;

  muldiv_hilo dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sgn(in_sgn), .in_a(in_a), .in_b(in_b),
    .wb_valid(wb_valid), .wb_data(wb_data));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, input bit s);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_sgn = s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input bit sel_hi, input logic [63:0] exp, input string tag);
    do_op(sel_hi ? RHI : RLO, '0, '0, 1'b0);
    @(negedge clk);
    chk(!wb_valid, {tag, " early wb"}, {63'd0, wb_valid}, 64'd0);
    @(negedge clk);
    chk(wb_valid && wb_data == exp, tag, wb_data, exp);
  endtask

  task automatic busy_len(input int exp, input string tag);
    int n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk(n == exp, tag, 64'(n), 64'(exp));
  endtask

  task automatic t_reset();
    chk(in_ready && !wb_valid, "R1 ready/wb", {62'd0, in_ready, wb_valid}, 64'd2);
    rd(1'b1, 64'd0, "R1 HI zero");
    rd(1'b0, 64'd0, "R1 LO zero");
  endtask

  task automatic t_mulw();
    do_op(MULW, 64'h1234_5678_FFFF_FFFD, 64'h0000_0000_0000_0007, 1'b1);
    chk(in_ready, "R2 occupancy", {63'd0, in_ready}, 64'd1);
    rd(1'b0, 64'hFFFF_FFFF_FFFF_FFEB, "R2 signed LO");
    rd(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 signed HI");
    do_op(MULW, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1'b0);
    rd(1'b0, 64'hFFFF_FFFF_FFFF_FFFE, "R2 unsigned LO");
    rd(1'b1, 64'h0000_0000_0000_0001, "R2 unsigned HI");
    do_op(MULW, 64'd3, 64'd5, 1'b0);
    rd(1'b0, 64'd15, "R3 read right after mul");
  endtask

  task automatic t_muld();
    do_op(MULD, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0);
    busy_len(2, "R4 busy cycles");
    rd(1'b1, 64'd1, "R4 unsigned HI");
    rd(1'b0, 64'hFFFF_FFFF_FFFF_FFFE, "R4 unsigned LO");
    do_op(MULD, -64'sd3, 64'd5, 1'b1);
    busy_len(2, "R4 busy cycles signed");
    rd(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 signed HI");
    rd(1'b0, -64'sd15, "R4 signed LO");
  endtask

  task automatic t_macc();
    do_op(WHI, 64'd0, 64'd0, 1'b0);
    do_op(WLO, 64'd0, 64'd0, 1'b0);
    do_op(MACC, 64'd3, 64'd4, 1'b1);
    chk(in_ready, "R5 no stall", {63'd0, in_ready}, 64'd1);
    do_op(MACC, -64'sd2, 64'd5, 1'b1);
    @(negedge clk);
    chk(wb_valid && wb_data == 64'd12, "R5 first wb", wb_data, 64'd12);
    @(negedge clk);
    chk(wb_valid && wb_data == 64'd2, "R5 second wb", wb_data, 64'd2);
    @(negedge clk);
    do_op(WHI, 64'd1, 64'd0, 1'b0);
    do_op(WLO, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    do_op(MACC, 64'd1, 64'd1, 1'b0);
    repeat (3) @(negedge clk);
    rd(1'b0, 64'd0, "R5 carry LO");
    rd(1'b1, 64'd2, "R5 carry HI");
  endtask

  task automatic t_mt();
    do_op(WHI, 64'hCAFE_0000_1234_5678, 64'd0, 1'b0);
    chk(in_ready, "R8 occupancy", {63'd0, in_ready}, 64'd1);
    do_op(WLO, 64'h0BAD_F00D_0000_0001, 64'd0, 1'b0);
    rd(1'b1, 64'hCAFE_0000_1234_5678, "R8 HI");
    rd(1'b0, 64'h0BAD_F00D_0000_0001, "R8 LO");
  endtask

  task automatic t_divw();
    bit seen;
    do_op(DIVW, 64'h0000_0000_FFFF_FFF9, 64'd2, 1'b1);
    busy_len(35, "R6 busy cycles");
    rd(1'b0, 64'hFFFF_FFFF_FFFF_FFFD, "R6 signed quotient");
    rd(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R6 signed remainder");
    do_op(DIVW, 64'hABCD_0000_0000_0064, 64'd7, 1'b0);
    seen = 0;
    in_valid = 1'b1; in_op = WLO; in_a = 64'hDEAD; in_b = '0;
    repeat (10) begin @(negedge clk); seen |= wb_valid; end
    in_valid = 1'b0;
    chk(!seen, "R9 no wb while busy", {63'd0, seen}, 64'd0);
    busy_len(25, "R6 busy cycles unsigned");
    rd(1'b0, 64'd14, "R9 R6 quotient kept");
    rd(1'b1, 64'd2, "R6 unsigned remainder");
  endtask

  task automatic t_divd();
    do_op(DIVD, 64'h8000_0000_0000_0000, 64'd3, 1'b0);
    busy_len(71, "R7 busy cycles");
    rd(1'b0, 64'h2AAA_AAAA_AAAA_AAAA, "R7 unsigned quotient");
    rd(1'b1, 64'd2, "R7 unsigned remainder");
    do_op(DIVD, 64'd100, -64'sd9, 1'b1);
    busy_len(71, "R7 busy cycles signed");
    rd(1'b0, -64'sd11, "R7 signed quotient");
    rd(1'b1, 64'd1, "R7 signed remainder");
    do_op(DIVD, 64'd12345, 64'd0, 1'b0);
    busy_len(71, "R10 busy cycles");
    rd(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 zero divisor LO");
    rd(1'b1, 64'd12345, "R10 zero divisor HI");
  endtask

  task automatic t_unused();
    do_op(WHI, 64'd77, 64'd0, 1'b0);
    do_op(WLO, 64'd88, 64'd0, 1'b0);
    for (int k = 9; k < 16; k++) begin
      do_op(4'(k), 64'hFFFF, 64'hFFFF, 1'b1);
      chk(in_ready, "R11 accepted", {63'd0, in_ready}, 64'd1);
    end
    rd(1'b1, 64'd77, "R11 HI unchanged");
    rd(1'b0, 64'd88, "R11 LO unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mulw();
    t_muld();
    t_macc();
    t_mt();
    t_divw();
    t_divd();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule